// File: doc/BRIEF.md
# Staged One-Bit Mapper Control Bank

This block holds sixteen one-bit control flags that steer a memory mapper. It sits on an 8-bit CPU bus with a 24-bit address. Software cannot change a live flag directly. A write goes into a shadow (pending) copy. The whole shadow is moved into the live set in one step when software writes a dedicated commit slot. Because of this, the address decoder downstream never sees a map that is only half updated.

A write is staged only when the new bit differs from the live value of that flag. A staged write raises a dirty marker, and a commit does something only when that marker is set. Reads return the live flag in the top data bit. The other bits carry the open-bus byte that the system supplies. A one-cycle pulse after each effective commit tells the decoder to latch the new flag set.

Top module: `staged_cfg_regs`

## Requirements
- R1: The block responds only when address bits 23:20 are 0 (banks 0x00–0x0F) and address bits 15:0 equal 0x5000. Any other address reads as the open-bus byte unchanged and ignores writes.
- R2: Address bits 19:16 select one of sixteen flags, numbered 0x0 to 0xF. Flag 0xE is the commit slot.
- R3: The value written to a flag is bit 7 of the write data. Bits 6:0 of the write data are ignored.
- R4: A read is registered. One cycle after the read edge, a read of flags 0x0–0xD gives the live flag in bit 7 and open-bus bits 6:0 in bits 6:0.
- R5: A read of flag 0xE or 0xF gives 0 in bit 7 and open-bus bits 6:0 in bits 6:0.
- R6: A write to any flag other than 0xE whose bit differs from the live value stores the bit in the pending copy and sets the dirty marker. The live flags do not change until a commit.
- R7: A write whose bit equals the live value is ignored. It does not set the dirty marker and does not undo an earlier staged value of that flag.
- R8: A write to 0xE while dirty copies every pending bit into the live set at that edge and clears the dirty marker. The commit pulse is high for exactly the following cycle.
- R9: A write to 0xE while clean has no effect, and no pulse is produced.
- R10: After synchronous reset the live flags are 0xCBEF (flags 0x4, 0xA, 0xC and 0xD are 0, all others 1). The pending copy equals the live set, the dirty marker is clear, the read data is 0 and the pulse is low.
- R11: An operation takes effect on the edge where its strobe is high. If both strobes are high, only the write happens and the read data holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | CPU bus address |
| bus_wdata | input | 8 | Write data; bit 7 carries the flag value |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| open_bus | input | 8 | Current open-bus byte |
| rd_data | output | 8 | Registered read data |
| active_bits | output | 16 | Live flag set, bit n is flag n |
| commit_pulse | output | 1 | One-cycle pulse after an effective commit |

## Verification
Reads sweep all sixteen slots under several open-bus bytes. This separates the live-bit splice on 0x0–0xD from the forced zero on 0xE/0xF and from open-bus passthrough on misses. Writes flip every flag and then commit, which separates staging from live update. Repeated, equal-valued and miss-addressed writes show whether dirty tracking is change-only, whether a commit while clean is inert, and whether near-miss offsets or banks leak into the bank. A cycle with both strobes high shows that the write has priority.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int unsigned REG_COUNT = 16;
    localparam int unsigned IDX_W     = $clog2(REG_COUNT);
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned ADDR_W    = 24;
    localparam int unsigned OFFS_W    = 16;
    localparam int unsigned SEL_LO    = OFFS_W;
    localparam int unsigned SEL_HI    = SEL_LO + IDX_W - 1;

    localparam logic [OFFS_W-1:0]    SLOT_OFFSET = 16'h5000;
    localparam logic [IDX_W-1:0]     COMMIT_IDX  = 4'hE;
    localparam logic [IDX_W-1:0]     FIRST_WO    = 4'hE;
    localparam logic [REG_COUNT-1:0] RESET_BITS  = 16'hCBEF;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } slot_sel_t;

    function automatic logic is_write_only(input logic [IDX_W-1:0] idx);
        return idx >= FIRST_WO;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfgbank_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output slot_sel_t     sel,
    output bus_op_e       op
);

    localparam int unsigned BANK_HI_W = AW - SEL_HI - 1;

    logic bank_ok;
    logic offs_ok;

    always_comb begin
        bank_ok = (addr[AW-1:SEL_HI+1] == '0);
        offs_ok = (addr[OFFS_W-1:0] == SLOT_OFFSET);
        sel.hit = bank_ok && offs_ok;
        sel.idx = addr[SEL_HI:SEL_LO];
        if (wr)
            op = OP_WRITE;
        else if (rd)
            op = OP_READ;
        else
            op = OP_IDLE;
    end

    initial begin
        AST_BANK_FIELD_WIDE: assert (BANK_HI_W >= 1) else $error("bank field empty"); // R1
    end

endmodule

// File: rtl/cfg_stage_bank.sv
module cfg_stage_bank
    import cfgbank_pkg::*;
#(
    parameter int unsigned NREG = REG_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_op_e         op,
    input  slot_sel_t       sel,
    input  logic            wbit,
    output logic [NREG-1:0] active,
    output logic            commit_pulse
);

    logic [NREG-1:0] pending;
    logic            dirty;
    logic            wr_slot;
    logic            commit_req;
    logic            commit_fire;
    logic            stage_req;

    always_comb begin
        wr_slot     = (op == OP_WRITE) && sel.hit;
        commit_req  = wr_slot && (sel.idx == COMMIT_IDX);
        commit_fire = commit_req && dirty;
        stage_req   = wr_slot && (sel.idx != COMMIT_IDX) && (wbit != active[sel.idx]);
    end

    for (genvar i = 0; i < NREG; i++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst)
                pending[i] <= RESET_BITS[i];
            else if (stage_req && (sel.idx == IDX_W'(i)))
                pending[i] <= wbit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active       <= RESET_BITS[NREG-1:0];
            dirty        <= 1'b0;
            commit_pulse <= 1'b0;
        end else begin
            commit_pulse <= commit_fire;
            if (commit_fire) begin
                active <= pending;
                dirty  <= 1'b0;
            end else if (stage_req) begin
                dirty  <= 1'b1;
            end
        end
    end

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |=> !commit_pulse); // R8
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (rst)
        commit_fire |=> (active == $past(pending)) && !dirty); // R8
    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_fire |=> $stable(active)); // R6
    AST_CLEAN_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (commit_req && !dirty) |=> !commit_pulse); // R9
    AST_SAME_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_slot && (sel.idx != COMMIT_IDX) && (wbit == active[sel.idx]) && !dirty) |=> !dirty); // R7

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfgbank_pkg::*;
#(
    parameter int unsigned NREG = REG_COUNT,
    parameter int unsigned DW   = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_op_e         op,
    input  slot_sel_t       sel,
    input  logic [NREG-1:0] active,
    input  logic [DW-1:0]   open_bus,
    output logic [DW-1:0]   rd_data
);

    logic          live_bit;
    logic [DW-1:0] rd_next;

    always_comb begin
        live_bit = is_write_only(sel.idx) ? 1'b0 : active[sel.idx];
        if (sel.hit)
            rd_next = {live_bit, open_bus[DW-2:0]};
        else
            rd_next = open_bus;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (op == OP_READ)
            rd_data <= rd_next;
    end

    AST_RD_MISS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ && !sel.hit) |=> rd_data == $past(open_bus)); // R1
    AST_RD_WO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ && sel.hit && sel.idx >= FIRST_WO) |=> !rd_data[DW-1]); // R5
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op != OP_READ) |=> $stable(rd_data)); // R11

endmodule

// File: rtl/staged_cfg_regs.sv
module staged_cfg_regs
    import cfgbank_pkg::*;
#(
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned NREG = REG_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [DW-1:0]   open_bus,
    output logic [DW-1:0]   rd_data,
    output logic [NREG-1:0] active_bits,
    output logic            commit_pulse
);

    slot_sel_t sel;
    bus_op_e   op;

    cfg_addr_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .sel  (sel),
        .op   (op)
    );

    cfg_stage_bank #(.NREG(NREG)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .op           (op),
        .sel          (sel),
        .wbit         (bus_wdata[DW-1]),
        .active       (active_bits),
        .commit_pulse (commit_pulse)
    );

    cfg_read_mux #(.NREG(NREG), .DW(DW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .sel      (sel),
        .active   (active_bits),
        .open_bus (open_bus),
        .rd_data  (rd_data)
    );

    AST_RESET_LIVE: assert property (@(posedge clk)
        rst |=> (active_bits == RESET_BITS[NREG-1:0]) && !commit_pulse && (rd_data == '0)); // R10

endmodule

// File: tb/staged_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module staged_cfg_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  open_bus;
    logic [7:0]  rd_data;
    logic [15:0] active_bits;
    logic        commit_pulse;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [15:0] m_active;
    logic [15:0] m_pending;
    logic        m_dirty;

    always #2 clk = ~clk;

    staged_cfg_regs dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .open_bus     (open_bus),
        .rd_data      (rd_data),
        .active_bits  (active_bits),
        .commit_pulse (commit_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_slot(input logic [23:0] a);
        return (a[23:20] == 4'h0) && (a[15:0] == 16'h5000);
    endfunction

    function automatic logic [23:0] slot(input int idx);
        return {4'h0, idx[3:0], 16'h5000};
    endfunction

    // model update for one write; returns expected pulse
    function automatic bit model_write(input logic [23:0] a, input logic [7:0] d);
        logic [3:0] ix;
        ix = a[19:16];
        if (!in_slot(a)) return 1'b0;
        if (ix == 4'hE) begin
            if (m_dirty) begin
                m_active = m_pending;
                m_dirty  = 1'b0;
                return 1'b1;
            end
            return 1'b0;
        end
        if (d[7] != m_active[ix]) begin
            m_pending[ix] = d[7];
            m_dirty       = 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic bus_write(input logic [23:0] a, input logic [7:0] d, input string req);
        bit exp_p;
        exp_p = model_write(a, d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        check(active_bits == m_active, {req, " live"}, active_bits, m_active);
        check(commit_pulse == exp_p, {req, " pulse"}, commit_pulse, exp_p);
    endtask

    task automatic bus_read(input logic [23:0] a, input logic [7:0] ob, input string req);
        logic [7:0] exp;
        logic [3:0] ix;
        ix = a[19:16];
        if (!in_slot(a))
            exp = ob;
        else if (ix >= 4'hE)
            exp = {1'b0, ob[6:0]};
        else
            exp = {m_active[ix], ob[6:0]};
        bus_addr = a; open_bus = ob; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic idle_pulse_low(input string req);
        @(posedge clk); @(negedge clk);
        check(commit_pulse == 1'b0, req, commit_pulse, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] obs [4];
        logic [7:0] prev;
        bit         exp_p;
        obs[0] = 8'h00; obs[1] = 8'hFF; obs[2] = 8'h5A; obs[3] = 8'hA5;
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_rd = 1'b0; bus_wr = 1'b0; open_bus = '0;
        m_active = 16'hCBEF; m_pending = 16'hCBEF; m_dirty = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(active_bits == 16'hCBEF, "R10 live", active_bits, 16'hCBEF);
        check(rd_data == 8'h00, "R10 rd_data", rd_data, 0);
        check(commit_pulse == 1'b0, "R10 pulse", commit_pulse, 0);

        // R2 R4 R5 read sweep
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 4; k++)
                bus_read(slot(i), obs[k], (i >= 14) ? "R5 read" : "R4 R2 read");

        // R6 stage a flip of every flag except commit slot
        for (int i = 0; i < 16; i++)
            if (i != 14)
                bus_write(slot(i), {~m_active[i], 7'h15}, "R6 stage");
        // R8 commit
        bus_write(slot(14), 8'h00, "R8 commit");
        idle_pulse_low("R8 pulse one cycle");
        for (int i = 0; i < 16; i++)
            bus_read(slot(i), 8'h3C, "R4 after commit");
        // R9 commit while clean
        bus_write(slot(14), 8'h80, "R9 clean commit");
        bus_write(slot(14), 8'h00, "R9 clean commit again");

        // R7 equal-value write ignored, staged value kept
        bus_write(slot(0), {~m_active[0], 7'h00}, "R7 stage flip");
        bus_write(slot(0), {m_active[0], 7'h00}, "R7 equal write");
        bus_write(slot(14), 8'h00, "R7 commit keeps stage");
        bus_write(slot(5), {m_active[5], 7'h7F}, "R7 equal while clean");
        bus_write(slot(14), 8'h00, "R7 no dirty from equal");

        // R3 only bit 7 of write data matters
        bus_write(slot(1), m_active[1] ? 8'h7F : 8'hFF, "R3 stage");
        bus_write(slot(14), 8'h00, "R3 commit");
        bus_write(slot(1), m_active[1] ? 8'h7F : 8'h80, "R3 low bits");
        bus_write(slot(14), 8'h00, "R3 commit 2");

        // R1 misses: writes ignored, reads open bus
        bus_write(24'h005001, {~m_active[0], 7'h00}, "R1 offset miss");
        bus_write(24'h005FFF, {~m_active[0], 7'h00}, "R1 offset miss hi");
        bus_write(24'h105000, {~m_active[0], 7'h00}, "R1 bank miss");
        bus_write(24'h8F5000, {~m_active[15], 7'h00}, "R1 high bank miss");
        bus_write(slot(14), 8'h00, "R1 commit after misses");
        bus_write(slot(2), {~m_active[2], 7'h00}, "R1 stage");
        bus_write(24'h0E5001, 8'h00, "R1 commit miss");
        bus_write(24'h1E5000, 8'h00, "R1 commit bank miss");
        bus_write(slot(14), 8'h00, "R1 real commit");
        bus_read(24'h005001, 8'hC3, "R1 read miss");
        bus_read(24'h305000, 8'h81, "R1 read bank miss");
        bus_read(24'h0F4FFF, 8'h7E, "R1 read near miss");

        // R11 both strobes: write wins, read data holds
        bus_read(slot(3), 8'h11, "R11 setup read");
        prev = rd_data;
        exp_p = model_write(slot(3), {~m_active[3], 7'h00});
        bus_addr = slot(3); bus_wdata = {m_pending[3], 7'h00}; open_bus = 8'hEE;
        bus_rd = 1'b1; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check(rd_data == prev, "R11 read held", rd_data, prev);
        check(commit_pulse == exp_p, "R11 pulse", commit_pulse, exp_p);
        bus_write(slot(14), 8'h00, "R11 write took effect");
        bus_read(slot(3), 8'h00, "R11 readback");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule